// File: doc/BRIEF.md
# Addressed Byte Distributor

The block takes bytes from an upstream first-word-fall-through queue and hands each one to one of several slow bit-serial transmitter channels. Every byte carries a destination code. The code and the byte go out together on one bus that reaches all channels. Each channel compares the code with its own fixed index and claims the byte only on a match. Routing therefore never indexes an array. A code that names no channel draws no claim, and the byte is dropped.

A central two-state sequencer runs the exchange. In the first cycle it presents the queue head. In the second cycle it reads two wired-OR returns: the registered claim flags and the acknowledges. If nothing claimed the byte, it pops the byte and raises a one-cycle error pulse. If a channel claimed it, the sequencer waits until that channel is idle and takes the byte into its one-byte holding register, and only then pops the queue. The head stays on the bus until the pop, so a busy channel stalls the source and no byte is lost.

Each channel holds one byte at a time and shifts it out on its own line. The frame is a low start bit followed by the data bits, least significant first. Each bit lasts a fixed number of clocks. The line rests high when the channel is idle.

Top module: `byte_distributor`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the sequencer returns to its presenting state. After that edge, `src_pop`, `drop_err`, `addr_claimed`, `byte_taken` and every `ch_busy` bit are 0, and every `ch_line` bit is 1.
- R2: A byte whose destination code d is below NUM_CH (14 by default) is sent only on `ch_line[d]`. Every other line stays high, and at most one channel starts a frame in any cycle.
- R3: `addr_claimed` rises exactly one clock after a valid queue head is first presented, and never in the cycle of presentation itself.
- R4: A byte whose destination code is NUM_CH or above (codes 14 and 15 with a 4-bit field) is popped in the second cycle with `drop_err` high and `addr_claimed` low. No channel becomes busy.
- R5: When every target channel is idle, back-to-back queued bytes are popped once every two clocks.
- R6: A byte aimed at a busy channel is not popped, and `addr_claimed` stays high, until that channel's busy flag clears. The byte is accepted in the first cycle in which the flag is low.
- R7: `src_pop` is high only in a cycle where a byte is either accepted (`byte_taken`) or discarded (`drop_err`). The two never occur together.
- R8: `byte_taken` is high only when the claiming channel is idle. On the next edge exactly one channel goes from idle to busy.
- R9: An accepted byte starts on its line one clock after acceptance. The frame is a start bit of 0 and then data bits 0 to DATA_W-1, each held for BIT_CYCLES clocks. The busy flag clears (DATA_W+1)*BIT_CYCLES clocks after the frame starts, and the line is high while the channel is idle.
- R10: `drop_err` lasts exactly one clock for each discarded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Upstream queue holds a byte at its head |
| src_dest | input | DEST_W | Destination code of the head byte |
| src_data | input | DATA_W | Data of the head byte |
| src_pop | output | 1 | Removes the head byte from the queue |
| drop_err | output | 1 | One-cycle pulse when a byte is discarded unclaimed |
| addr_claimed | output | 1 | OR of all channel claim flags |
| byte_taken | output | 1 | OR of all channel acknowledges |
| ch_busy | output | NUM_CH | Per-channel busy flags |
| ch_line | output | NUM_CH | Per-channel serial outputs, idle high |

## Verification
Two events can fall on the same cycle. One is a channel finishing its last bit. The other is the sequencer, in its waiting state, holding a byte for that same channel. The bench provokes this by queueing two bytes to one channel back to back. It checks that the second byte is held through the whole first frame and that it is taken in exactly the cycle after the busy flag falls, with nothing lost and no idle gap. It also discards a bad code while another channel is still transmitting, to show that a drop does not disturb a frame already under way.

// File: rtl/byte_dist_pkg.sv
// Shared types for the addressed byte distributor.
// Assumes: nothing beyond standard SystemVerilog.
package byte_dist_pkg;

    // Sequencer phases: present the head, then decide on the claim returns.
    typedef enum logic {
        SEQ_PRESENT = 1'b0,
        SEQ_DECIDE  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/dist_sequencer.sv
// Central sequencer. It presents the queue head for one cycle, then decides
// from the wired-OR claim and acknowledge returns: it drops an unclaimed
// byte, takes a claimed one as soon as the owner acknowledges, and waits
// otherwise.
// Assumes: the queue head stays stable until src_pop; the claim returns are
// registered one cycle after presentation.
module dist_sequencer
    import byte_dist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_valid,
    input  logic claim_any,
    input  logic ack_any,
    output logic present,
    output logic decide,
    output logic src_pop,
    output logic drop_err
);

    seq_state_t state_q;

    // Decode the phase strobes and the pop/discard outcome.
    always_comb begin
        present  = (state_q == SEQ_PRESENT) && src_valid;
        decide   = (state_q == SEQ_DECIDE);
        drop_err = decide && !claim_any;
        src_pop  = decide && (!claim_any || ack_any);
    end

    // Advance between the present and decide phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_PRESENT;
        end else if (present) begin
            state_q <= SEQ_DECIDE;
        end else if (src_pop) begin
            state_q <= SEQ_PRESENT;
        end
    end

endmodule

// File: rtl/dist_channel.sv
// One transmitter channel. It matches the broadcast destination against its
// fixed index, keeps the claim until the byte leaves the bus, acknowledges
// only when idle, and shifts the held byte out as a start bit followed by
// the data, LSB first, each bit lasting BIT_CYCLES clocks.
// Assumes: present, decide and pop come from the central sequencer.
module dist_channel #(
    parameter int CH_IDX     = 0,
    parameter int DATA_W     = 8,
    parameter int DEST_W     = 4,
    parameter int BIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              present,
    input  logic              decide,
    input  logic              pop,
    input  logic [DEST_W-1:0] bus_dest,
    input  logic [DATA_W-1:0] bus_data,
    output logic              claim,
    output logic              ack,
    output logic              busy,
    output logic              line
);

    localparam int FRAME_BITS = DATA_W + 1;
    localparam int TICK_W     = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam int BITC_W     = $clog2(FRAME_BITS + 1);
    localparam logic [DEST_W-1:0] MY_CODE   = DEST_W'(CH_IDX);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(BIT_CYCLES - 1);
    localparam logic [BITC_W-1:0] BIT_LAST  = BITC_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shift_q;
    logic [TICK_W-1:0]     tick_q;
    logic [BITC_W-1:0]     bit_q;

    // Take the byte only while idle and holding the claim.
    assign ack  = decide && claim && !busy;
    assign line = busy ? shift_q[0] : 1'b1;

    // Latch the address match at presentation; release it when the byte leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            claim <= 1'b0;
        end else if (present) begin
            claim <= (bus_dest == MY_CODE);
        end else if (pop) begin
            claim <= 1'b0;
        end
    end

    // Load the holding register on ack, then shift one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shift_q <= '1;
            tick_q  <= '0;
            bit_q   <= '0;
        end else if (ack) begin
            busy    <= 1'b1;
            shift_q <= {bus_data, 1'b0};
            tick_q  <= '0;
            bit_q   <= '0;
        end else if (busy) begin
            if (tick_q == TICK_LAST) begin
                tick_q  <= '0;
                shift_q <= {1'b1, shift_q[FRAME_BITS-1:1]};
                if (bit_q == BIT_LAST) begin
                    busy <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/byte_distributor.sv
// Top level. The sequencer broadcasts the queue head to NUM_CH channels and
// reduces their claim and acknowledge outputs into wired-OR returns.
// Assumes: NUM_CH fits in the destination field; the upstream queue shows its
// head combinationally and removes it on src_pop.
module byte_distributor #(
    parameter int NUM_CH     = 14,
    parameter int DATA_W     = 8,
    parameter int DEST_W     = 4,
    parameter int BIT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [DEST_W-1:0] src_dest,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    output logic              drop_err,
    output logic              addr_claimed,
    output logic              byte_taken,
    output logic [NUM_CH-1:0] ch_busy,
    output logic [NUM_CH-1:0] ch_line
);

    logic [NUM_CH-1:0] claim_vec;
    logic [NUM_CH-1:0] ack_vec;
    logic              present;
    logic              decide;

    // Wired-OR returns toward the sequencer.
    assign addr_claimed = |claim_vec;
    assign byte_taken   = |ack_vec;

    dist_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .claim_any (addr_claimed),
        .ack_any   (byte_taken),
        .present   (present),
        .decide    (decide),
        .src_pop   (src_pop),
        .drop_err  (drop_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dist_channel #(
            .CH_IDX     (g),
            .DATA_W     (DATA_W),
            .DEST_W     (DEST_W),
            .BIT_CYCLES (BIT_CYCLES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .present  (present),
            .decide   (decide),
            .pop      (src_pop),
            .bus_dest (src_dest),
            .bus_data (src_data),
            .claim    (claim_vec[g]),
            .ack      (ack_vec[g]),
            .busy     (ch_busy[g]),
            .line     (ch_line[g])
        );
    end

endmodule

// File: rtl/byte_distributor_chk.sv
// Property checker for byte_distributor, attached by bind below.
// Assumes: it observes the top-level ports only.
module byte_distributor_chk #(
    parameter int NUM_CH = 14,
    parameter int DEST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_valid,
    input logic [DEST_W-1:0] src_dest,
    input logic              src_pop,
    input logic              drop_err,
    input logic              addr_claimed,
    input logic              byte_taken,
    input logic [NUM_CH-1:0] ch_busy,
    input logic [NUM_CH-1:0] ch_line
);

    // R7
    pop_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (byte_taken ^ drop_err));

    // R4
    drop_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |-> (!addr_claimed && (int'(src_dest) >= NUM_CH)));

    // R10
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> !drop_err);

    // R3
    claim_after_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_claimed) |-> $past(src_valid));

    // R8
    take_starts_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_taken |=> ($countones(ch_busy & ~$past(ch_busy)) == 1));

    // R2
    single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_busy & ~$past(ch_busy)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_idle
        // R9
        idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_busy[g] |-> ch_line[g]);
    end

endmodule

bind byte_distributor byte_distributor_chk #(
    .NUM_CH (NUM_CH),
    .DEST_W (DEST_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_valid    (src_valid),
    .src_dest     (src_dest),
    .src_pop      (src_pop),
    .drop_err     (drop_err),
    .addr_claimed (addr_claimed),
    .byte_taken   (byte_taken),
    .ch_busy      (ch_busy),
    .ch_line      (ch_line)
);

// File: tb/byte_distributor_tb.sv
// Directed bench for byte_distributor: one task per scenario.
module byte_distributor_tb;

    localparam int NCH   = 14;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int B     = 4;
    localparam int FRAME = DW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid;
    logic [AW-1:0] src_dest;
    logic [DW-1:0] src_data;
    logic          src_pop, drop_err, addr_claimed, byte_taken;
    logic [NCH-1:0] ch_busy, ch_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench-side queue model feeding the block.
    logic [AW-1:0] q_dest [0:255];
    logic [DW-1:0] q_data [0:255];
    int head = 0;
    int tail = 0;

    assign src_valid = (head != tail);
    assign src_dest  = q_dest[head[7:0]];
    assign src_data  = q_data[head[7:0]];

    always_ff @(posedge clk) begin
        if (rst_n && src_pop) head <= head + 1;
    end

    always #4 clk = ~clk;

    byte_distributor #(.NUM_CH(NCH), .DATA_W(DW), .DEST_W(AW), .BIT_CYCLES(B)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
        .src_data(src_data), .src_pop(src_pop), .drop_err(drop_err),
        .addr_claimed(addr_claimed), .byte_taken(byte_taken),
        .ch_busy(ch_busy), .ch_line(ch_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [AW-1:0] d, input logic [DW-1:0] v);
        q_dest[tail[7:0]] = d;
        q_data[tail[7:0]] = v;
        tail++;
    endtask

    function automatic logic fbit(input logic [DW-1:0] d, input int k);
        return (k == 0) ? 1'b0 : d[k-1];
    endfunction

    // Called at the negedge of the accepting cycle; follows the whole frame.
    task automatic check_frame(input int ch, input logic [DW-1:0] d);
        logic [NCH-1:0] mask;
        mask = NCH'(1) << ch;
        for (int k = 0; k < FRAME; k++) begin
            if (k == 0) @(negedge clk);
            else repeat (B) @(negedge clk);
            chk("R9 frame bit", 32'(ch_line[ch]), 32'(fbit(d, k)));
            chk("R2 other lines idle", 32'(ch_line | mask), 32'({NCH{1'b1}}));
        end
        repeat (B) @(negedge clk);
        chk("R9 busy clears", 32'(ch_busy[ch]), 32'd0);
        chk("R9 line idle high", 32'(ch_line[ch]), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 pop", 32'(src_pop), 32'd0);
        chk("R1 drop_err", 32'(drop_err), 32'd0);
        chk("R1 claimed", 32'(addr_claimed), 32'd0);
        chk("R1 taken", 32'(byte_taken), 32'd0);
        chk("R1 busy", 32'(ch_busy), 32'd0);
        chk("R1 lines", 32'(ch_line), 32'({NCH{1'b1}}));
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single(input int ch, input logic [DW-1:0] d);
        push(AW'(ch), d);
        #1;
        chk("R3 no claim while presenting", 32'(addr_claimed), 32'd0);
        @(negedge clk);
        chk("R3 claim one clock later", 32'(addr_claimed), 32'd1);
        chk("R7 pop on accept", 32'(src_pop), 32'd1);
        chk("R8 taken when idle", 32'(byte_taken), 32'd1);
        chk("R7 no drop on accept", 32'(drop_err), 32'd0);
        check_frame(ch, d);
    endtask

    task automatic t_drop(input logic [AW-1:0] d);
        push(d, 8'hEE);
        @(negedge clk);
        chk("R4 drop_err", 32'(drop_err), 32'd1);
        chk("R4 pop on drop", 32'(src_pop), 32'd1);
        chk("R4 no claim", 32'(addr_claimed), 32'd0);
        chk("R7 no take on drop", 32'(byte_taken), 32'd0);
        @(negedge clk);
        chk("R10 pulse ends", 32'(drop_err), 32'd0);
        chk("R4 no channel busy", 32'(ch_busy), 32'd0);
        chk("R4 lines idle", 32'(ch_line), 32'({NCH{1'b1}}));
    endtask

    task automatic t_throughput();
        push(4'd0, 8'h11);
        push(4'd1, 8'h22);
        push(4'd2, 8'h33);
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            chk("R5 pop every two clocks", 32'(src_pop), 32'(i % 2));
        end
        chk("R5 three channels busy", 32'(ch_busy), 32'h7);
        repeat (FRAME * B + 4) @(negedge clk);
        chk("R5 all idle again", 32'(ch_busy), 32'd0);
    endtask

    task automatic t_stall(input logic [DW-1:0] a, input logic [DW-1:0] b);
        push(4'd5, a);
        push(4'd5, b);
        @(negedge clk);
        chk("R7 first accepted", 32'(src_pop), 32'd1);
        for (int n = 2; n <= 1 + FRAME * B; n++) begin
            @(negedge clk);
            chk("R6 held while busy", 32'(src_pop), 32'd0);
            if (n >= 3) chk("R6 claim kept", 32'(addr_claimed), 32'd1);
            chk("R9 first frame bit", 32'(ch_line[5]), 32'(fbit(a, (n - 2) / B)));
        end
        @(negedge clk);
        chk("R6 busy just cleared", 32'(ch_busy[5]), 32'd0);
        chk("R6 accepted once idle", 32'(src_pop), 32'd1);
        chk("R6 taken once idle", 32'(byte_taken), 32'd1);
        check_frame(5, b);
    endtask

    task automatic t_drop_while_busy();
        push(4'd3, 8'hA5);
        push(4'd15, 8'h00);
        push(4'd4, 8'h3C);
        @(negedge clk);
        chk("R7 first accepted", 32'(byte_taken), 32'd1);
        @(negedge clk);
        chk("R5 gap cycle", 32'(src_pop), 32'd0);
        @(negedge clk);
        chk("R4 drop during frame", 32'(drop_err), 32'd1);
        chk("R4 frame undisturbed", 32'(ch_busy), 32'h8);
        @(negedge clk);
        chk("R10 single pulse", 32'(drop_err), 32'd0);
        @(negedge clk);
        chk("R2 next channel taken", 32'(byte_taken), 32'd1);
        @(negedge clk);
        chk("R2 two channels busy", 32'(ch_busy), 32'h18);
        chk("R2 ch4 start bit", 32'(ch_line[4]), 32'd0);
        repeat (FRAME * B + 4) @(negedge clk);
        chk("R9 both idle", 32'(ch_busy), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single(0, 8'h96);
        t_single(13, 8'h5A);
        t_drop(4'd14);
        t_drop(4'd15);
        t_throughput();
        t_stall(8'hC3, 8'h81);
        t_drop_while_busy();
        t_single(7, 8'hFF);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule